// File: doc/BRIEF.md
# Segmented Address Translation Unit

This block converts a segment value and an offset into a linear address. Two modes are offered. In real mode the 16-bit segment value is multiplied by sixteen and added to the low 16 bits of the offset, giving a 20-bit address that wraps within 1 MB. In protected mode the segment value acts as a selector. Its upper 13 bits index a descriptor table in memory. The unit reads the 8-byte descriptor through a 32-bit memory read port, extracts the 32-bit segment base and the 20-bit segment limit, checks the offset against the limit, and returns base plus offset.

Software first loads a 48-bit table register holding the table base and the table limit. It then presents requests one at a time on a valid/ready port. Each request produces exactly one response carrying either a linear address or a fault code. A real-mode request, or a protected-mode request whose descriptor falls outside the table, is answered without touching memory. A protected-mode request that passes the table check costs two memory reads.

Top module: `seg_xlate`

## Requirements
- R1: While reset is held and right after it is released, `req_ready` is 1, `rsp_valid` is 0 and `mem_req_valid` is 0.
- R2: A real-mode request (`req_prot`=0) returns `rsp_addr` = (`req_seg`*16 + `req_off[15:0]`) mod 2^20, with bits 31:20 zero and `req_off[31:16]` ignored. The response is registered on the clock edge that accepts the request, and no memory read is issued.
- R3: A pulse on `tbl_load` stores `tbl_value`, with bits 47:16 as the table base and bits 15:0 as the table limit in bytes. A load in the same cycle as an accepted request takes effect for that request.
- R4: A protected-mode request reads the descriptor at table base + `req_seg[15:3]`*8 as two 32-bit reads, the low word at that address first and then the high word at that address + 4. `req_seg[2:0]` has no effect.
- R5: If `req_seg[15:3]`*8 + 7 exceeds the table limit, the response is a fault with code 1. It is registered on the accepting edge, and no memory read is issued. An index whose last byte equals the limit is valid.
- R6: The descriptor layout uses low word bits 15:0 = limit[15:0], low word bits 31:16 = base[15:0], high word bits 7:0 = base[23:16], high word bits 19:16 = limit[19:16], and high word bits 31:24 = base[31:24]. High word bits 15:8 and 23:20 are ignored. On success `rsp_addr` = (base + `req_off`) mod 2^32.
- R7: If `req_off` is greater than the 20-bit descriptor limit, the response is a fault with code 2. An offset equal to the limit succeeds.
- R8: `mem_req_valid` stays high with `mem_req_addr` unchanged until `mem_req_ready` is seen. The block waits any number of cycles for `mem_rsp_valid`.
- R9: `req_ready` is low from the cycle after a protected request starts its descriptor reads until its response. The response is registered on the edge that takes the high word.
- R10: A fault response has `rsp_fault`=1, `rsp_addr`=0 and a nonzero `rsp_code`. A successful response has `rsp_fault`=0 and `rsp_code`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tbl_load | input | 1 | Load strobe for the table register |
| tbl_value | input | 48 | Table base (47:16) and table limit (15:0) |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request ready, high when idle |
| req_prot | input | 1 | 1 = protected mode, 0 = real mode |
| req_seg | input | 16 | Segment value or selector |
| req_off | input | 32 | Offset |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory read request accepted |
| mem_req_addr | output | 32 | Memory read byte address |
| mem_rsp_valid | input | 1 | Memory read data valid |
| mem_rsp_data | input | 32 | Memory read data |
| rsp_valid | output | 1 | Response valid for one cycle |
| rsp_fault | output | 1 | Response is a fault |
| rsp_code | output | 2 | 0 ok, 1 table limit fault, 2 segment limit fault |
| rsp_addr | output | 32 | Linear address, zero on fault |

## Verification
A table register load and the acceptance of a protected-mode request can fall on the same clock edge. The bench provokes this by raising `tbl_load` in the same cycle as `req_valid`, with a selector whose descriptor lies just past the old table limit but inside the new one. A correct design reads the descriptor and returns an address. A design that used the stale register would return a table fault. A second same-cycle load then shrinks the limit by one byte, and the bench expects a fault with code 1.

// File: rtl/seg_xlate_pkg.sv
// Package: shared widths, fault codes, descriptor type and fetch states.
// Assumes byte addressing and a 32-bit memory word.
package seg_xlate_pkg;

    localparam int unsigned SX_ADDR_W   = 32;
    localparam int unsigned SX_SEG_W    = 16;
    localparam int unsigned SX_REAL_W   = 20;
    localparam int unsigned SX_SHIFT    = 4;
    localparam int unsigned SX_TLIM_W   = 16;
    localparam int unsigned SX_SLIM_W   = 20;
    localparam int unsigned SX_DSC_SH   = 3;   // log2 of descriptor size in bytes

    typedef enum logic [1:0] {
        FLT_NONE  = 2'd0,
        FLT_TABLE = 2'd1,
        FLT_SEG   = 2'd2
    } flt_code_e;

    typedef struct packed {
        logic [SX_ADDR_W-1:0] base;
        logic [SX_SLIM_W-1:0] limit;
    } seg_desc_t;

    typedef enum logic [2:0] {
        FS_IDLE    = 3'd0,
        FS_LO_REQ  = 3'd1,
        FS_LO_WAIT = 3'd2,
        FS_HI_REQ  = 3'd3,
        FS_HI_WAIT = 3'd4
    } fetch_state_e;

endpackage

// File: rtl/seg_real_path.sv
// Real-mode path: scales the segment value by 2^SHIFT and adds the
// 16-bit offset, keeping REAL_W bits (wraps at the top). Purely combinational.
module seg_real_path #(
    parameter int unsigned SEG_W  = 16,
    parameter int unsigned SHIFT  = 4,
    parameter int unsigned REAL_W = 20,
    parameter int unsigned ADDR_W = 32
) (
    input  logic [SEG_W-1:0]  seg,
    input  logic [SEG_W-1:0]  off_lo,
    output logic [ADDR_W-1:0] lin
);
    localparam int unsigned SUM_W = REAL_W + 1;

    logic [SUM_W-1:0] sum;

    // Shift-and-add, then truncate to the real-mode address width.
    always_comb begin
        sum = SUM_W'({seg, {SHIFT{1'b0}}}) + SUM_W'(off_lo);
        lin = ADDR_W'(sum[REAL_W-1:0]);
    end
endmodule

// File: rtl/seg_desc_decode.sv
// Descriptor decoder: pulls the segment base and limit out of the two
// descriptor words. Assumes little-endian byte order within each word.
module seg_desc_decode
    import seg_xlate_pkg::*;
(
    input  logic [31:0] word_lo,
    input  logic [31:0] word_hi,
    output seg_desc_t   desc
);
    logic unused_hi_bits;

    // Gather base and limit fields from their byte positions.
    always_comb begin
        desc.base  = {word_hi[31:24], word_hi[7:0], word_lo[31:16]};
        desc.limit = {word_hi[19:16], word_lo[15:0]};
    end

    assign unused_hi_bits = ^{word_hi[23:20], word_hi[15:8]};
endmodule

// File: rtl/seg_desc_fetch.sv
// Descriptor fetcher: issues two word reads (low word, then high word at
// +4) under a valid/ready request handshake and waits any time for data.
// Assumes the memory answers each accepted request exactly once, in order.
module seg_desc_fetch
    import seg_xlate_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    output logic              busy,
    output logic              done,
    output logic [31:0]       word_lo,
    output logic [31:0]       word_hi,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [31:0]       mem_rsp_data
);
    localparam logic [ADDR_W-1:0] WORD_STEP = ADDR_W'(4);

    fetch_state_e state_q;
    logic [ADDR_W-1:0] addr_q;
    logic [31:0]       lo_q;

    // Sequence the two reads and hold the address across back-pressure.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FS_IDLE;
            addr_q  <= '0;
            lo_q    <= '0;
        end else begin
            case (state_q)
                FS_IDLE: begin
                    if (start) begin
                        addr_q  <= start_addr;
                        state_q <= FS_LO_REQ;
                    end
                end
                FS_LO_REQ: begin
                    if (mem_req_ready) state_q <= FS_LO_WAIT;
                end
                FS_LO_WAIT: begin
                    if (mem_rsp_valid) begin
                        lo_q    <= mem_rsp_data;
                        addr_q  <= addr_q + WORD_STEP;
                        state_q <= FS_HI_REQ;
                    end
                end
                FS_HI_REQ: begin
                    if (mem_req_ready) state_q <= FS_HI_WAIT;
                end
                FS_HI_WAIT: begin
                    if (mem_rsp_valid) state_q <= FS_IDLE;
                end
                default: state_q <= FS_IDLE;
            endcase
        end
    end

    // Drive the memory port and the completion strobe.
    always_comb begin
        mem_req_valid = (state_q == FS_LO_REQ) || (state_q == FS_HI_REQ);
        mem_req_addr  = addr_q;
        busy          = (state_q != FS_IDLE);
        done          = (state_q == FS_HI_WAIT) && mem_rsp_valid;
        word_lo       = lo_q;
        word_hi       = mem_rsp_data;
    end
endmodule

// File: rtl/seg_xlate.sv
// Segmented address translation top: holds the table register, checks
// the selector against the table limit, runs the real-mode adder or the
// descriptor fetch, checks the segment limit and registers one response
// per request. Accepts one request at a time; responses are not stalled.
module seg_xlate
    import seg_xlate_pkg::*;
#(
    parameter int unsigned ADDR_W = SX_ADDR_W,
    parameter int unsigned SEG_W  = SX_SEG_W,
    parameter int unsigned REAL_W = SX_REAL_W,
    parameter int unsigned SHIFT  = SX_SHIFT
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        tbl_load,
    input  logic [ADDR_W+SX_TLIM_W-1:0] tbl_value,
    input  logic                        req_valid,
    output logic                        req_ready,
    input  logic                        req_prot,
    input  logic [SEG_W-1:0]            req_seg,
    input  logic [ADDR_W-1:0]           req_off,
    output logic                        mem_req_valid,
    input  logic                        mem_req_ready,
    output logic [ADDR_W-1:0]           mem_req_addr,
    input  logic                        mem_rsp_valid,
    input  logic [31:0]                 mem_rsp_data,
    output logic                        rsp_valid,
    output logic                        rsp_fault,
    output logic [1:0]                  rsp_code,
    output logic [ADDR_W-1:0]           rsp_addr
);
    localparam int unsigned IDX_W  = SEG_W - SX_DSC_SH;
    localparam int unsigned TLIM_W = SX_TLIM_W;

    logic [ADDR_W-1:0] tbl_base_q, eff_base;
    logic [TLIM_W-1:0] tbl_lim_q, eff_lim;
    logic [IDX_W-1:0]  sel_idx;
    logic [TLIM_W-1:0] dsc_last;
    logic [ADDR_W-1:0] dsc_addr;
    logic              tbl_fault;
    logic              accept;
    logic              fetch_start;
    logic              fetch_busy, fetch_done;
    logic [31:0]       word_lo, word_hi;
    seg_desc_t         desc;
    logic [ADDR_W-1:0] real_lin;
    logic [ADDR_W-1:0] off_q;

    // Hold the table register between loads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tbl_base_q <= '0;
            tbl_lim_q  <= '0;
        end else if (tbl_load) begin
            tbl_base_q <= tbl_value[ADDR_W+TLIM_W-1:TLIM_W];
            tbl_lim_q  <= tbl_value[TLIM_W-1:0];
        end
    end

    // Same-cycle load forwarding plus the table-limit check.
    always_comb begin
        eff_base    = tbl_load ? tbl_value[ADDR_W+TLIM_W-1:TLIM_W] : tbl_base_q;
        eff_lim     = tbl_load ? tbl_value[TLIM_W-1:0] : tbl_lim_q;
        sel_idx     = req_seg[SEG_W-1:SX_DSC_SH];
        dsc_last    = {sel_idx, {SX_DSC_SH{1'b1}}};
        tbl_fault   = dsc_last > eff_lim;
        dsc_addr    = eff_base + ADDR_W'({sel_idx, {SX_DSC_SH{1'b0}}});
        req_ready   = !fetch_busy;
        accept      = req_valid && req_ready;
        fetch_start = accept && req_prot && !tbl_fault;
    end

    // Keep the offset of a protected request for the final add.
    always_ff @(posedge clk) begin
        if (!rst_n) off_q <= '0;
        else if (fetch_start) off_q <= req_off;
    end

    seg_real_path #(
        .SEG_W (SEG_W),
        .SHIFT (SHIFT),
        .REAL_W(REAL_W),
        .ADDR_W(ADDR_W)
    ) real_i (
        .seg   (req_seg),
        .off_lo(req_off[SEG_W-1:0]),
        .lin   (real_lin)
    );

    seg_desc_fetch #(
        .ADDR_W(ADDR_W)
    ) fetch_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (fetch_start),
        .start_addr   (dsc_addr),
        .busy         (fetch_busy),
        .done         (fetch_done),
        .word_lo      (word_lo),
        .word_hi      (word_hi),
        .mem_req_valid(mem_req_valid),
        .mem_req_ready(mem_req_ready),
        .mem_req_addr (mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data (mem_rsp_data)
    );

    seg_desc_decode decode_i (
        .word_lo(word_lo),
        .word_hi(word_hi),
        .desc   (desc)
    );

    // Register exactly one response per request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_fault <= 1'b0;
            rsp_code  <= FLT_NONE;
            rsp_addr  <= '0;
        end else begin
            rsp_valid <= 1'b0;
            if (accept && !req_prot) begin
                rsp_valid <= 1'b1;
                rsp_fault <= 1'b0;
                rsp_code  <= FLT_NONE;
                rsp_addr  <= real_lin;
            end else if (accept && tbl_fault) begin
                rsp_valid <= 1'b1;
                rsp_fault <= 1'b1;
                rsp_code  <= FLT_TABLE;
                rsp_addr  <= '0;
            end else if (fetch_done) begin
                rsp_valid <= 1'b1;
                if (off_q > ADDR_W'(desc.limit)) begin
                    rsp_fault <= 1'b1;
                    rsp_code  <= FLT_SEG;
                    rsp_addr  <= '0;
                end else begin
                    rsp_fault <= 1'b0;
                    rsp_code  <= FLT_NONE;
                    rsp_addr  <= desc.base + off_q;
                end
            end
        end
    end
endmodule

// File: rtl/seg_xlate_chk.sv
// Checker for seg_xlate: protocol and response-shape properties over the
// top-level ports. Attached by the bind at the end of this file.
module seg_xlate_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic        req_prot,
    input logic        mem_req_valid,
    input logic        mem_req_ready,
    input logic [31:0] mem_req_addr,
    input logic        rsp_valid,
    input logic        rsp_fault,
    input logic [1:0]  rsp_code,
    input logic [31:0] rsp_addr
);
    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R8

    AST_NO_ACCEPT_IN_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !req_ready); // R9

    AST_FAULT_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_fault |-> rsp_addr == 32'd0 && rsp_code != 2'd0); // R10

    AST_OK_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_fault |-> rsp_code == 2'd0); // R10

    AST_REAL_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && !req_prot |=> rsp_valid && !rsp_fault && rsp_addr[31:20] == 12'd0); // R2

    AST_REAL_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && !req_prot |=> !mem_req_valid); // R2
endmodule

bind seg_xlate seg_xlate_chk chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_prot     (req_prot),
    .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready),
    .mem_req_addr (mem_req_addr),
    .rsp_valid    (rsp_valid),
    .rsp_fault    (rsp_fault),
    .rsp_code     (rsp_code),
    .rsp_addr     (rsp_addr)
);

// File: tb/seg_xlate_tb_top.sv
// Scoreboard bench for seg_xlate: the driver pushes expected responses,
// the monitor pops and compares them, and a memory model with varying
// delays serves descriptor reads and checks their addresses.
module seg_xlate_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tbl_load = 1'b0;
    logic [47:0] tbl_value = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_prot = 1'b0;
    logic [15:0] req_seg = '0;
    logic [31:0] req_off = '0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        rsp_valid;
    logic        rsp_fault;
    logic [1:0]  rsp_code;
    logic [31:0] rsp_addr;

    always #2 clk = ~clk;  // 250 MHz

    seg_xlate dut_i (.*);

    typedef struct {
        logic [31:0] addr;
        logic        fault;
        logic [1:0]  code;
        int          cyc;
        string       req;
    } exp_t;

    exp_t        exp_q[$];
    logic [31:0] mem_exp_q[$];
    logic [31:0] mem [0:255];
    logic [31:0] d_base [0:15];
    logic [19:0] d_lim  [0:15];
    logic [31:0] sh_base = '0;
    logic [15:0] sh_lim = '0;
    int checks = 0;
    int errors = 0;
    int cyc = 0;
    logic [15:0] lfsr = 16'hACE1;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Build a descriptor in bench memory and remember its fields (R6 layout).
    task automatic put_desc(int idx, logic [31:0] base, logic [19:0] lim);
        int w;
        w = (32'h100 + idx * 8) >> 2;
        mem[w]     = {base[15:0], lim[15:0]};
        mem[w + 1] = {base[31:24], 4'hC, lim[19:16], 8'h9A, base[23:16]};
        d_base[idx] = base;
        d_lim[idx]  = lim;
    endtask

    // Driver: waits for ready, drives one request, pushes the expectation.
    task automatic send(bit prot, logic [15:0] seg, logic [31:0] off,
                        bit ld, logic [47:0] tv, string req);
        exp_t e;
        int idx;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        if (ld) begin
            tbl_load  = 1'b1;
            tbl_value = tv;
            sh_base   = tv[47:16];
            sh_lim    = tv[15:0];
        end
        req_valid = 1'b1;
        req_prot  = prot;
        req_seg   = seg;
        req_off   = off;
        e.req = req;
        e.fault = 1'b0;
        e.code = 2'd0;
        e.addr = '0;
        e.cyc = -1;
        if (!prot) begin
            e.addr = ({12'd0, seg, 4'd0} + {16'd0, off[15:0]}) & 32'h000F_FFFF;
            e.cyc  = cyc + 1;
        end else begin
            idx = int'(seg[15:3]);
            if (idx * 8 + 7 > int'(sh_lim)) begin
                e.fault = 1'b1;
                e.code  = 2'd1;
                e.cyc   = cyc + 1;
            end else begin
                mem_exp_q.push_back(sh_base + idx * 8);
                mem_exp_q.push_back(sh_base + idx * 8 + 4);
                if (off > {12'd0, d_lim[idx]}) begin
                    e.fault = 1'b1;
                    e.code  = 2'd2;
                end else begin
                    e.addr = d_base[idx] + off;
                end
            end
        end
        exp_q.push_back(e);
        @(negedge clk);
        req_valid = 1'b0;
        tbl_load  = 1'b0;
    endtask

    task automatic load_tbl(logic [31:0] base, logic [15:0] lim);
        @(negedge clk);
        tbl_load  = 1'b1;
        tbl_value = {base, lim};
        sh_base   = base;
        sh_lim    = lim;
        @(negedge clk);
        tbl_load  = 1'b0;
    endtask

    // Monitor: compares each response against the scoreboard head.
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            if (rst_n && rsp_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R10", "unexpected response", rsp_addr, 0);
                end else begin
                    e = exp_q.pop_front();
                    check(rsp_addr == e.addr, e.req, "address", rsp_addr, e.addr);
                    check(rsp_fault == e.fault && rsp_code == e.code, e.req,
                          "fault/code", {rsp_fault, rsp_code}, {e.fault, e.code});
                    if (e.cyc >= 0)
                        check(cyc == e.cyc, e.req, "latency", cyc, e.cyc);
                end
            end
        end
    end

    // Memory model: random ready, random response delay, address check (R4).
    initial begin
        bit pend = 1'b0;
        int pend_cnt = 0;
        logic [31:0] pend_addr = '0;
        logic [31:0] ea;
        forever begin
            @(negedge clk);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            mem_rsp_valid = 1'b0;
            if (pend) begin
                if (pend_cnt == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = mem[pend_addr[9:2]];
                    pend = 1'b0;
                end else begin
                    pend_cnt--;
                end
            end
            mem_req_ready = rst_n && !pend && lfsr[0];
            if (mem_req_valid && mem_req_ready) begin
                pend      = 1'b1;
                pend_addr = mem_req_addr;
                pend_cnt  = int'(lfsr[3:1]);
                if (mem_exp_q.size() == 0) begin
                    check(1'b0, "R4", "unexpected read", mem_req_addr, 0);
                end else begin
                    ea = mem_exp_q.pop_front();
                    check(mem_req_addr == ea, "R4", "descriptor read address", mem_req_addr, ea);
                end
            end
        end
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "R8", "watchdog expired", exp_q.size(), 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Main sequence.
    initial begin
        for (int i = 0; i < 256; i++) mem[i] = '0;
        for (int i = 0; i < 16; i++) begin
            d_base[i] = '0;
            d_lim[i]  = '0;
        end
        repeat (3) @(negedge clk);
        check(req_ready == 1'b1 && rsp_valid == 1'b0 && mem_req_valid == 1'b0, "R1",
              "state in reset", {req_ready, rsp_valid, mem_req_valid}, 3'b100);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1 && rsp_valid == 1'b0 && mem_req_valid == 1'b0, "R1",
              "state after reset", {req_ready, rsp_valid, mem_req_valid}, 3'b100);

        put_desc(1, 32'h0040_0000, 20'hFFFFF);
        put_desc(2, 32'hA1B2_C3D4, 20'h5E6F7);
        put_desc(3, 32'hFFFF_FFF0, 20'h00100);
        put_desc(7, 32'h0000_7000, 20'h00010);
        put_desc(8, 32'h0000_8000, 20'hFFFFF);
        load_tbl(32'h0000_0100, 16'h003F);   // R3: eight descriptors

        send(0, 16'h1234, 32'h0000_0010, 0, '0, "R2");
        send(0, 16'hFFFF, 32'h0000_FFFF, 0, '0, "R2");   // wraps at 1 MB
        send(0, 16'h0100, 32'hABCD_0020, 0, '0, "R2");   // upper offset ignored
        send(1, 16'h000B, 32'h0000_0010, 0, '0, "R4");   // low selector bits ignored
        send(1, 16'h0013, 32'h0005_E6F7, 0, '0, "R6");   // every field byte distinct
        send(1, 16'h0018, 32'h0000_0020, 0, '0, "R6");   // base + offset wraps
        send(1, 16'h0018, 32'h0000_0100, 0, '0, "R7");   // equal to limit passes
        send(1, 16'h0018, 32'h0000_0101, 0, '0, "R7");   // one past limit faults
        send(1, 16'h0038, 32'h0000_0000, 0, '0, "R5");   // last in-table entry
        send(1, 16'h0040, 32'h0000_0000, 0, '0, "R5");   // one entry past table
        send(1, 16'h0040, 32'h0000_0005, 1, {32'h0000_0100, 16'h0047}, "R3");
        send(1, 16'h0040, 32'h0000_0005, 1, {32'h0000_0100, 16'h0046}, "R5");
        send(0, 16'h0F00, 32'h0000_0001, 0, '0, "R9");   // real after protected
        send(1, 16'h0008, 32'h0010_0000, 0, '0, "R10");  // just past 20-bit limit

        while (exp_q.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
        check(mem_exp_q.size() == 0, "R4", "pending descriptor reads", mem_exp_q.size(), 0);
        check(req_ready == 1'b1 && mem_req_valid == 1'b0, "R9", "idle at end",
              {req_ready, mem_req_valid}, 2'b10);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule